// File: doc/BRIEF.md
# Command-Driven I2C Byte Master

This block is an I2C bus master run by a processor through two 8-bit registers: a control/status register and a data register. Software picks an action in a 2-bit command field and then starts it by writing the data register. The available actions are: no action, one byte transfer, a START condition followed by a byte transfer, and a STOP condition. A byte transfer sends the written byte most significant bit first and collects the eight bits seen on SDA into a receive byte. It then sends one acknowledge bit whose value software chose, and records the acknowledge bit that came back. Software reads the received byte back from the data register.

Each bus phase lasts one half bit period, counted by an internal prescaler (`HALF_DIV` clock cycles, about 100 kHz SCL at the default). Both bus lines are open-drain. The outputs request a pull-low, and releasing a line leaves it to the external pull-up. When no sequence is running, two drive bits in the control register set SCL and SDA directly, so software can free a stuck bus by hand. A synchronised copy of the SDA line can be read at any time.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both lines are released, the control register reads 0x1C while SDA is high (bits 1:0 command = 00, bit 2 SCL drive = 1, bit 3 SDA drive = 1, bit 4 SDA level, bit 5 ACK-send = 0, bit 6 ACK-received = 0, bit 7 busy = 0), and the data register reads 0x00.
- R2: A data-register write (`wr_sel`=1) with command 00 starts nothing: busy stays 0 and neither line changes.
- R3: Command 01 puts the 8 written bits on SDA MSB first, one per SCL pulse, and shifts the SDA value sampled while SCL is high into the received byte, which a data-register read (`rd_sel`=1) returns.
- R4: After the eighth bit a ninth SCL pulse carries the ACK-send bit (control bit 5), and the SDA value seen during it is stored in control bit 6.
- R5: Command 10 first releases both lines, then pulls SDA low while SCL is high (one START condition), then pulls SCL low, then performs the byte transfer of R3/R4.
- R6: Command 11 pulls both lines low, then releases SCL, then releases SDA, producing exactly one STOP condition, and leaves both lines released.
- R7: During a byte transfer SDA changes only while SCL is low, so no START or STOP condition appears on the bus.
- R8: Busy (control bit 7) reads 1 from the clock after an accepted data write until the sequence ends. A byte transfer ends with SCL held low.
- R9: Writes to either register while busy are ignored. The command, the ACK-send bit and the byte in flight are unchanged.
- R10: While idle, a control write sets the lines directly: bit 2 = 0 pulls SCL low and bit 3 = 0 pulls SDA low, and 1 releases each line.
- R11: Control bit 4 reads the level of the SDA line after a two-stage synchroniser.
- R12: Each SCL high phase of a byte transfer lasts exactly `HALF_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 data |
| rd_data | output | 8 | Read data of the selected register |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench runs a small open-drain slave model. It returns its own byte and acknowledge, and the line is the wired-AND of both sides. A design that sampled on the wrong phase, or shifted LSB first, would therefore return a byte other than the AND of the transmitted and slave bytes. A monitor counts START and STOP conditions. An SDA edge while SCL is high during a byte, a missing START, or a STOP with the release order swapped would show up as a wrong count. The repeated START after a byte, with SCL low and SDA possibly held low by the acknowledge, is tested along with writes issued mid-transfer. A design that accepted those writes would corrupt the byte on the bus or the command field. The bench also measures the SCL high width and the line state after each command, which catches an off-by-one prescaler or a byte that ends with SCL released.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_BYTE  = 2'b01,
    CMD_START = 2'b10,
    CMD_STOP  = 2'b11
  } i2cm_cmd_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_ST_REL,
    SQ_ST_SDA,
    SQ_ST_SCL,
    SQ_BIT_LO,
    SQ_BIT_HI,
    SQ_BYTE_END,
    SQ_SP_LOW,
    SQ_SP_SCL,
    SQ_SP_SDA
  } i2cm_state_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int HALF_DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

  // R12: a tick only ever follows a full count of the half period
  p_tick_spacing_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  i2cm_cmd_e         cmd,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ack_send,
  input  logic              tick,
  input  logic              sda_s,
  input  logic              man_load,
  input  logic              man_scl,
  input  logic              man_sda,
  output logic              busy,
  output logic              scl_rel,
  output logic              sda_rel,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_rcv
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] ACK_SLOT = BW'(DATA_W);

  i2cm_state_e       state_q, state_d;
  logic              scl_q, scl_d, sda_q, sda_d;
  logic              pend_q, pend_d, pval_q, pval_d;
  logic [DATA_W:0]   sh_q, sh_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              ack_q, ack_d;
  logic [BW-1:0]     cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    pend_d  = 1'b0;
    pval_d  = pval_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    ack_d   = ack_q;
    cnt_d   = cnt_q;
    // SDA update deferred one cycle after SCL has gone low
    if (pend_q) sda_d = pval_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (man_load) begin
          scl_d = man_scl;
          sda_d = man_sda;
        end
        if (go) begin
          sh_d = {tx_byte, ack_send};
          unique case (cmd)
            CMD_START: begin
              state_d = SQ_ST_REL;
              scl_d   = 1'b1;
              sda_d   = 1'b1;
            end
            CMD_BYTE: begin
              state_d = SQ_BIT_LO;
              scl_d   = 1'b0;
              pend_d  = 1'b1;
              pval_d  = tx_byte[DATA_W-1];
              cnt_d   = '0;
            end
            CMD_STOP: begin
              state_d = SQ_SP_LOW;
              scl_d   = 1'b0;
              pend_d  = 1'b1;
              pval_d  = 1'b0;
            end
            default: state_d = SQ_IDLE;
          endcase
        end
      end
      SQ_ST_REL: if (tick) begin state_d = SQ_ST_SDA; sda_d = 1'b0; end
      SQ_ST_SDA: if (tick) begin state_d = SQ_ST_SCL; scl_d = 1'b0; end
      SQ_ST_SCL: if (tick) begin
        state_d = SQ_BIT_LO;
        cnt_d   = '0;
        pend_d  = 1'b1;
        pval_d  = sh_q[DATA_W];
      end
      SQ_BIT_LO: if (tick) begin state_d = SQ_BIT_HI; scl_d = 1'b1; end
      SQ_BIT_HI: if (tick) begin
        scl_d = 1'b0;
        if (cnt_q == ACK_SLOT) begin
          ack_d   = sda_s;
          state_d = SQ_BYTE_END;
        end else begin
          rx_d    = {rx_q[DATA_W-2:0], sda_s};
          sh_d    = {sh_q[DATA_W-1:0], 1'b0};
          cnt_d   = cnt_q + 1'b1;
          state_d = SQ_BIT_LO;
          pend_d  = 1'b1;
          pval_d  = sh_q[DATA_W-1];
        end
      end
      SQ_BYTE_END: if (tick) state_d = SQ_IDLE;
      SQ_SP_LOW:   if (tick) begin state_d = SQ_SP_SCL; scl_d = 1'b1; end
      SQ_SP_SCL:   if (tick) begin state_d = SQ_SP_SDA; sda_d = 1'b1; end
      SQ_SP_SDA:   if (tick) state_d = SQ_IDLE;
      default:     state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      pend_q  <= 1'b0;
      pval_q  <= 1'b1;
      sh_q    <= '0;
      rx_q    <= '0;
      ack_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      pend_q  <= pend_d;
      pval_q  <= pval_d;
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      ack_q   <= ack_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy    = (state_q != SQ_IDLE);
  assign scl_rel = scl_q;
  assign sda_rel = sda_q;
  assign rx_byte = rx_q;
  assign ack_rcv = ack_q;

  // R7: inside a byte, SDA holds while SCL stays high
  p_sda_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q inside {SQ_BIT_LO, SQ_BIT_HI, SQ_BYTE_END}) && $past(scl_q) && scl_q)
      |-> $stable(sda_q));

  // R5: SDA is already low when START pulls SCL low
  p_start_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_ST_SCL && $past(state_q) == SQ_ST_SDA) |-> !sda_q);

  // R6: STOP finishes with both lines released
  p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(state_q) == SQ_SP_SDA) |-> (scl_q && sda_q));

  // R8: a byte finishes holding SCL low
  p_byte_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(state_q) == SQ_BYTE_END) |-> !scl_q);
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int HALF_DIV = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             sda_i,
  output logic             scl_low_o,
  output logic             sda_low_o
);
  i2cm_cmd_e        cmd_q, cmd_d;
  logic             acks_q, acks_d;
  logic             busy, tick, sda_s, scl_rel, sda_rel, ack_rcv;
  logic             ctrl_wr, go;
  logic [REG_W-1:0] rx_byte;

  assign ctrl_wr = wr_en && !wr_sel && !busy;
  assign go      = wr_en &&  wr_sel && !busy && (cmd_q != CMD_IDLE);

  always_comb begin
    cmd_d  = cmd_q;
    acks_d = acks_q;
    if (ctrl_wr) begin
      cmd_d  = i2cm_cmd_e'(wr_data[1:0]);
      acks_d = wr_data[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_IDLE;
      acks_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      acks_q <= acks_d;
    end
  end

  i2cm_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  i2cm_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sda_i),
    .q    (sda_s)
  );

  i2cm_seq #(.DATA_W(REG_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .cmd     (cmd_q),
    .tx_byte (wr_data),
    .ack_send(acks_q),
    .tick    (tick),
    .sda_s   (sda_s),
    .man_load(ctrl_wr),
    .man_scl (wr_data[2]),
    .man_sda (wr_data[3]),
    .busy    (busy),
    .scl_rel (scl_rel),
    .sda_rel (sda_rel),
    .rx_byte (rx_byte),
    .ack_rcv (ack_rcv)
  );

  assign rd_data   = rd_sel ? rx_byte
                            : {busy, ack_rcv, acks_q, sda_s, sda_rel, scl_rel, cmd_q};
  assign scl_low_o = !scl_rel;
  assign sda_low_o = !sda_rel;

  // R9: control writes during a sequence leave command and ACK-send alone
  p_busy_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !wr_sel) |=> ($stable(cmd_q) && $stable(acks_q)));

  // R2: a data write with command 00 never raises busy
  p_idle_nogo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_sel && cmd_q == CMD_IDLE) |=> !busy);

  // R8: an accepted data write raises busy on the next clock
  p_go_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_sel && cmd_q != CMD_IDLE) |=> busy);

  // R10: idle control write drives SCL as written
  p_manual_scl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && !wr_sel) |=> (scl_low_o == !$past(wr_data[2])));
endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  localparam int HD = 6;
  localparam int NV = 7;
  // {cmd[19:18], tx[17:10], slave byte[9:2], ack_send[1], slave ack[0]}
  localparam logic [19:0] VECS [NV] = '{
    {2'd2, 8'hA0, 8'hFF, 1'b1, 1'b0},
    {2'd1, 8'h5A, 8'hFF, 1'b1, 1'b1},
    {2'd1, 8'hFF, 8'h3C, 1'b0, 1'b1},
    {2'd2, 8'hA1, 8'hFF, 1'b1, 1'b0},
    {2'd1, 8'hFF, 8'h96, 1'b1, 1'b1},
    {2'd3, 8'h00, 8'hFF, 1'b0, 1'b0},
    {2'd0, 8'h77, 8'hFF, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       scl_low, sda_low, scl_bus, sda_bus, slave_low;
  logic       force_low = 1'b0;
  logic [7:0] slv_byte = 8'hFF;
  logic       slv_ack = 1'b1;
  logic       load_tog = 1'b0, load_seen = 1'b0;
  integer     load_val = -2;
  integer     sidx = -2;
  integer     n_start = 0, n_stop = 0, hi_cnt = 0, last_hi = 0;
  logic [8:0] cap9 = '0;
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  integer     n_chk = 0, n_fail = 0, cyc = 0;
  logic       done = 1'b0;

  assign slave_low = (sidx >= 0 && sidx <= 7) ? ~slv_byte[sidx[2:0]] :
                     (sidx == -1) ? ~slv_ack : 1'b0;
  assign scl_bus = ~scl_low;
  assign sda_bus = ~(sda_low | slave_low | force_low);

  i2c_cmd_master #(.HALF_DIV(HD)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sda_i(sda_bus),
    .scl_low_o(scl_low), .sda_low_o(sda_low)
  );

  // bus monitor and slave bit pointer
  always @(negedge clk) begin
    if (load_tog != load_seen) begin
      load_seen <= load_tog;
      sidx      <= load_val;
      n_start   <= 0;
      n_stop    <= 0;
    end else begin
      if (prev_scl && !scl_bus) begin
        sidx    <= sidx - 1;
        last_hi <= hi_cnt;
      end
      if (prev_scl && scl_bus && prev_sda && !sda_bus) n_start <= n_start + 1;
      if (prev_scl && scl_bus && !prev_sda && sda_bus) n_stop  <= n_stop + 1;
    end
    if (!prev_scl && scl_bus) begin
      cap9   <= {cap9[7:0], sda_bus};
      hi_cnt <= 1;
    end else if (scl_bus) begin
      hi_cnt <= hi_cnt + 1;
    end
    prev_scl <= scl_bus;
    prev_sda <= sda_bus;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    bit ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      rd(1'b0, v);
      if (!v[7]) begin ok = 1'b1; break; end
    end
    chk(req, 32'(ok), 32'd1);
  endtask

  task automatic arm_slave(input logic [7:0] b, input logic a, input integer idx);
    slv_byte = b; slv_ack = a; load_val = idx;
    load_tog = ~load_tog;
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [19:0] v);
    logic [1:0] cmd;
    logic [7:0] tx, slv, cur, rv;
    logic       acks, sack, scl0, sda0;
    cmd = v[19:18]; tx = v[17:10]; slv = v[9:2]; acks = v[1]; sack = v[0];
    rd(1'b0, cur);
    wr(1'b0, {2'b00, acks, 1'b0, cur[3], cur[2], cmd});
    arm_slave(slv, sack, (cmd == 2'd2) ? 8 : (cmd == 2'd1) ? 7 : -2);
    scl0 = scl_bus; sda0 = sda_bus;
    wr(1'b1, tx);
    rd(1'b0, rv);
    if (cmd == 2'd0) begin
      chk("R2 busy", 32'(rv[7]), 32'd0);
      repeat (3 * HD) @(negedge clk);
      chk("R2 lines", {30'd0, scl_bus, sda_bus}, {30'd0, scl0, sda0});
      return;
    end
    chk("R8 busy set", 32'(rv[7]), 32'd1);
    wait_idle("R8 completes");
    if (cmd == 2'd3) begin
      chk("R6 stop count", n_stop, 1);
      chk("R6 no start", n_start, 0);
      chk("R6 lines high", {30'd0, scl_bus, sda_bus}, 32'd3);
    end else begin
      rd(1'b1, rv);
      chk("R3 rx byte", 32'(rv), 32'(tx & slv));
      rd(1'b0, rv);
      chk("R4 ack rcv", 32'(rv[6]), 32'(acks & sack));
      chk("R3 bus bits", 32'(cap9), 32'({tx & slv, acks & sack}));
      chk("R5 start count", n_start, (cmd == 2'd2) ? 1 : 0);
      chk("R7 no stop", n_stop, 0);
      chk("R8 scl low", 32'(scl_bus), 32'd0);
      chk("R12 high width", last_hi, HD);
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", 32'(v), 32'h1C);
    rd(1'b1, v); chk("R1 data", 32'(v), 32'h00);
    chk("R1 lines", {30'd0, scl_low, sda_low}, 32'd0);

    // R10 manual drive
    wr(1'b0, 8'b0000_1000);
    chk("R10 scl pulled", {30'd0, scl_low, sda_low}, 32'd2);
    wr(1'b0, 8'b0000_0000);
    chk("R10 both pulled", {30'd0, scl_low, sda_low}, 32'd3);
    wr(1'b0, 8'b0000_0100);
    wr(1'b0, 8'b0000_1100);
    chk("R10 released", {30'd0, scl_low, sda_low}, 32'd0);

    // R11 SDA level
    force_low = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R11 level low", 32'(v[4]), 32'd0);
    force_low = 1'b0;
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R11 level high", 32'(v[4]), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9 writes during a transfer are dropped
    wr(1'b0, 8'b0010_1110);
    arm_slave(8'hFF, 1'b0, 8);
    wr(1'b1, 8'hC3);
    repeat (2 * HD) @(negedge clk);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'b0000_0011);
    rd(1'b0, v);
    chk("R9 cmd kept", 32'({v[5], v[1:0]}), 32'b110);
    wait_idle("R9 completes");
    rd(1'b1, v); chk("R9 rx byte", 32'(v), 32'hC3);
    chk("R9 bus bits", 32'(cap9), 32'({8'hC3, 1'b0}));
    chk("R9 start count", n_start, 1);
    run_vec({2'd3, 8'h00, 8'hFF, 1'b0, 1'b0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule